// File: doc/BRIEF.md
# Converter Power-Mode Sequencer

This block sits on the host side of a serial sampling converter. It moves the converter between three power states: normal, a light power-down (nap) and a deep power-down (sleep). The converter has no mode pins. It reads its mode from how many conversion-start pulses arrive while the serial clock stays still. The sequencer therefore turns a one-cycle mode request into a timed burst of start pulses. During that burst it holds the serial clock low. When the target is normal, it also counts out the recovery time that the old mode needs before conversions can be trusted. A separate read controller owns data capture. Its start and clock lines pass through this block only while the converter is awake and no sequence is running.

The controller is one FSM with four named states. ST_IDLE waits for requests. ST_HI drives a start pulse high. ST_LO is the low gap after each pulse. ST_WAIT counts the recovery time after a wake pulse. The transitions are:

- accept: ST_IDLE to ST_HI, on a request that is legal from the current mode.
- pulse_end: ST_HI to ST_LO, when the high time runs out.
- next_pulse: ST_LO to ST_HI, when more pulses are still owed.
- enter_done: ST_LO to ST_IDLE, after the last pulse of a power-down entry.
- recover: ST_LO to ST_WAIT, after a wake pulse.
- wake_done: ST_WAIT to ST_IDLE, when the recovery time has elapsed.

Two timing parameters are given in system-clock cycles: `HIGH_CYC`, the pulse high time, which must cover the minimum conversion time, and `LOW_CYC`, the gap between pulses. The recovery waits are also in cycles: `NAP_WAIT`, about one conversion period, and `SLEEP_WAIT`, about 1.1 ms for the reference to recharge.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, ready is 1, busy is 0, conv is 0 and sck is 0, and the tracked mode is normal.
- R2: A request with req_mode = 1 (nap) accepted in normal mode emits exactly 2 conv pulses and leaves ready at 0.
- R3: A request with req_mode = 2 (sleep) accepted in normal or nap mode emits exactly 4 conv pulses and leaves ready at 0.
- R4: Every sequencer pulse on conv stays high for exactly HIGH_CYC cycles and is followed by LOW_CYC low cycles. Busy therefore lasts n*(HIGH_CYC+LOW_CYC) cycles for an n-pulse entry.
- R5: sck is 0 in every cycle in which busy is 1.
- R6: A request with req_mode = 0 (normal) accepted in nap mode emits 1 pulse, then waits NAP_WAIT cycles. Ready rises in the cycle busy falls, after HIGH_CYC+LOW_CYC+NAP_WAIT busy cycles.
- R7: A request with req_mode = 0 accepted in sleep mode emits 1 pulse, then waits SLEEP_WAIT cycles, giving HIGH_CYC+LOW_CYC+SLEEP_WAIT busy cycles before ready rises.
- R8: busy is 1 from the cycle after acceptance until the sequence ends. A request presented while busy is 1 is dropped and adds no pulse.
- R9: A request for the current mode, for nap while in sleep, or with the reserved code 3 is ignored: busy stays 0, conv shows no pulse, and ready keeps its value.
- R10: While the block is idle in normal mode, conv follows rd_conv and sck follows rd_sck. In nap or sleep, both outputs are held at 0 regardless of rd_conv and rd_sck.
- R11: ready is 0 whenever busy is 1 and whenever the tracked mode is nap or sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode request strobe, sampled when busy is 0 |
| req_mode | input | 2 | Requested mode: 0 normal, 1 nap, 2 sleep, 3 reserved |
| rd_conv | input | 1 | Conversion start from the read controller |
| rd_sck | input | 1 | Serial clock from the read controller |
| busy | output | 1 | A pulse or recovery sequence is running |
| ready | output | 1 | Converter is awake and its conversions are valid |
| conv | output | 1 | Conversion-start line to the converter |
| sck | output | 1 | Serial clock line to the converter |

## Verification
If the FSM holds a wrong state, the ports show it as a wrong number of pulses or a wrong busy length. The pulse count differs from the expected one within one pulse period, and the busy length within one recovery window. If the tracked mode is wrong, two things show. A later request is accepted when it should be ignored, or the other way round, so busy rises or stays low in the cycle after the strobe. Also, ready and the pass-through of rd_conv and rd_sck take the wrong value in the very next idle cycle. A timer or gating fault shows within the affected pulse: either a high time that is not HIGH_CYC, or sck moving while busy is 1.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_NAP   = 2'd1,
        PM_SLEEP = 2'd2
    } pm_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2,
        ST_WAIT = 2'd3
    } seq_st_t;

    localparam int unsigned WAKE_PULSES  = 1;
    localparam int unsigned NAP_PULSES   = 2;
    localparam int unsigned SLEEP_PULSES = 4;
    localparam int unsigned PW           = 3;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/adc_pwr_timer.sv
module adc_pwr_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/adc_pwr_pcnt.sv
module adc_pwr_pcnt #(
    parameter int unsigned PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          dec,
    output logic [PW-1:0] left
);
    logic [PW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign left = left_q;

endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
    import adc_pwr_pkg::*;
#(
    parameter int unsigned HIGH_CYC   = 40,
    parameter int unsigned LOW_CYC    = 4,
    parameter int unsigned NAP_WAIT   = 40,
    parameter int unsigned SLEEP_WAIT = 110000,
    parameter int unsigned TW         = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_mode,
    input  logic          tmr_zero,
    input  logic [PW-1:0] pls_left,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          pls_load,
    output logic [PW-1:0] pls_val,
    output logic          pls_dec,
    output logic          conv_seq,
    output logic          busy,
    output logic          ready,
    output logic          pass_en
);
    localparam logic [TW-1:0] HI_LD    = TW'(HIGH_CYC - 1);
    localparam logic [TW-1:0] LO_LD    = TW'(LOW_CYC - 1);
    localparam logic [TW-1:0] NAP_LD   = TW'(NAP_WAIT - 1);
    localparam logic [TW-1:0] SLEEP_LD = TW'(SLEEP_WAIT - 1);

    seq_st_t state_q, state_d;
    pm_t     mode_q, mode_d;
    logic    deep_q, deep_d;

    logic          go;
    logic [PW-1:0] go_n;
    pm_t           go_mode;
    logic          go_deep;

    // Legality decode of a request against the tracked mode
    always_comb begin
        go      = 1'b0;
        go_n    = '0;
        go_mode = mode_q;
        go_deep = 1'b0;
        unique case (req_mode)
            2'd0: begin
                if (mode_q != PM_RUN) begin
                    go      = 1'b1;
                    go_n    = PW'(WAKE_PULSES);
                    go_mode = PM_RUN;
                    go_deep = (mode_q == PM_SLEEP);
                end
            end
            2'd1: begin
                if (mode_q == PM_RUN) begin
                    go      = 1'b1;
                    go_n    = PW'(NAP_PULSES);
                    go_mode = PM_NAP;
                end
            end
            2'd2: begin
                if (mode_q != PM_SLEEP) begin
                    go      = 1'b1;
                    go_n    = PW'(SLEEP_PULSES);
                    go_mode = PM_SLEEP;
                end
            end
            default: begin
                go = 1'b0;
            end
        endcase
        go = go & req_valid;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= PM_RUN;
            deep_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            deep_q  <= deep_d;
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        mode_d   = mode_q;
        deep_d   = deep_q;
        tmr_load = 1'b0;
        tmr_val  = HI_LD;
        pls_load = 1'b0;
        pls_val  = go_n;
        pls_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin                       // accept
                    state_d  = ST_HI;
                    mode_d   = go_mode;
                    deep_d   = go_deep;
                    tmr_load = 1'b1;
                    tmr_val  = HI_LD;
                    pls_load = 1'b1;
                end
            end
            ST_HI: begin
                if (tmr_zero) begin                 // pulse_end
                    state_d  = ST_LO;
                    tmr_load = 1'b1;
                    tmr_val  = LO_LD;
                    pls_dec  = 1'b1;
                end
            end
            ST_LO: begin
                if (tmr_zero) begin
                    if (pls_left != '0) begin       // next_pulse
                        state_d  = ST_HI;
                        tmr_load = 1'b1;
                        tmr_val  = HI_LD;
                    end else if (mode_q == PM_RUN) begin // recover
                        state_d  = ST_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = deep_q ? SLEEP_LD : NAP_LD;
                    end else begin                  // enter_done
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_zero) begin                 // wake_done
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        conv_seq = (state_q == ST_HI);
        busy     = (state_q != ST_IDLE);
        ready    = (state_q == ST_IDLE) && (mode_q == PM_RUN);
        pass_en  = ready;
    end

    // High-time tracker for the width check
    logic [TW-1:0] hi_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_len_q <= '0;
        else        hi_len_q <= conv_seq ? hi_len_q + 1'b1 : '0;
    end

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_seq && hi_len_q != '0) |-> (hi_len_q == TW'(HIGH_CYC)));

    p_busy_from_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    p_wake_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(state_q == ST_WAIT));

    p_pulse_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (pls_left == '0));

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int unsigned HIGH_CYC   = 40,
    parameter int unsigned LOW_CYC    = 4,
    parameter int unsigned NAP_WAIT   = 40,
    parameter int unsigned SLEEP_WAIT = 110000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       rd_conv,
    input  logic       rd_sck,
    output logic       busy,
    output logic       ready,
    output logic       conv,
    output logic       sck
);
    localparam int unsigned MAXV = max4(HIGH_CYC, LOW_CYC, NAP_WAIT, SLEEP_WAIT);
    localparam int unsigned TW   = $clog2(MAXV + 1);

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          pls_load, pls_dec;
    logic [PW-1:0] pls_val, pls_left;
    logic          conv_seq, pass_en;

    adc_pwr_fsm #(
        .HIGH_CYC  (HIGH_CYC),
        .LOW_CYC   (LOW_CYC),
        .NAP_WAIT  (NAP_WAIT),
        .SLEEP_WAIT(SLEEP_WAIT),
        .TW        (TW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_mode (req_mode),
        .tmr_zero (tmr_zero),
        .pls_left (pls_left),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .pls_load (pls_load),
        .pls_val  (pls_val),
        .pls_dec  (pls_dec),
        .conv_seq (conv_seq),
        .busy     (busy),
        .ready    (ready),
        .pass_en  (pass_en)
    );

    adc_pwr_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    adc_pwr_pcnt #(.PW(PW)) u_pcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pls_load),
        .load_val(pls_val),
        .dec     (pls_dec),
        .left    (pls_left)
    );

    // Line ownership: sequencer while running, read controller while awake and idle
    always_comb begin
        conv = conv_seq | (pass_en & rd_conv);
        sck  = pass_en & rd_sck;
    end

    p_sck_static_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sck);

    p_ready_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);

    p_gate_asleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ready) |-> (!conv && !sck));

endmodule

// File: tb/adc_pwr_seq_test.sv
module adc_pwr_seq_test;
    localparam int HI  = 3;
    localparam int LO  = 2;
    localparam int NW  = 4;
    localparam int SW  = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic rd_conv = 1'b0;
    logic rd_sck = 1'b0;
    logic busy, ready, conv, sck;

    always #5 clk = ~clk;

    adc_pwr_seq #(.HIGH_CYC(HI), .LOW_CYC(LO), .NAP_WAIT(NW), .SLEEP_WAIT(SW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .rd_conv(rd_conv), .rd_sck(rd_sck),
        .busy(busy), .ready(ready), .conv(conv), .sck(sck)
    );

    typedef struct {
        int    npulse;
        int    blen;
        logic  rdy;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   tests = 0;
    int   fails = 0;
    bit   done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Monitor: counts pulses and busy length, pops expected items
    int  m_pulses = 0, m_blen = 0, m_hi = 0;
    bit  m_sck_bad = 1'b0;
    logic p_busy = 1'b0, p_conv = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (busy) begin
                m_blen++;
                if (sck) m_sck_bad = 1'b1;
                if (conv) m_hi++;
                if (p_busy && p_conv && !conv) begin
                    m_pulses++;
                    chk(m_hi == HI, "R4 pulse high time", m_hi, HI);
                    m_hi = 0;
                end
                if (!p_busy && conv) m_hi = 1;
            end
            if (p_busy && !busy) begin
                if (p_conv) begin
                    m_pulses++;
                    chk(m_hi == HI, "R4 pulse high time", m_hi, HI);
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected sequence", m_pulses, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(m_pulses == e.npulse, {e.tag, " pulse count"}, m_pulses, e.npulse);
                    chk(m_blen == e.blen, {e.tag, " busy length"}, m_blen, e.blen);
                    chk(ready == e.rdy, {e.tag, " ready after"}, int'(ready), int'(e.rdy));
                    chk(!m_sck_bad, "R5 sck static while busy", int'(m_sck_bad), 0);
                end
                m_pulses = 0; m_blen = 0; m_hi = 0; m_sck_bad = 1'b0;
            end
            p_busy = busy;
            p_conv = busy ? conv : 1'b0;
        end
    end

    // Driver
    task automatic do_req(input logic [1:0] m, input int np, input int bl,
                          input logic rdy, input string tag, input bit poke);
        exp_t e;
        e.npulse = np; e.blen = bl; e.rdy = rdy; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        chk(ready == 1'b0, "R11 ready low while busy", int'(ready), 0);
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1; req_mode = 2'd2;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ign_req(input logic [1:0] m, input logic rdy_exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_mode = m;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b0, {tag, " ignored: busy"}, int'(busy), 0);
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && ready == rdy_exp, {tag, " ignored: busy/ready"},
            int'({busy, ready}), int'({1'b0, rdy_exp}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready", int'(ready), 1);
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(conv == 1'b0 && sck == 1'b0, "R1 conv/sck", int'({conv, sck}), 0);

        // R10 pass-through while awake
        rd_conv = 1'b1; rd_sck = 1'b1;
        #1;
        chk(conv == 1'b1 && sck == 1'b1, "R10 pass-through awake", int'({conv, sck}), 3);

        // R9 same-mode and reserved code ignored
        ign_req(2'd0, 1'b1, "R9 normal->normal");
        ign_req(2'd3, 1'b1, "R9 reserved code");

        // R2 nap entry, with R8 request poked mid-sequence
        do_req(2'd1, 2, 2*(HI+LO), 1'b0, "R2 nap entry", 1'b1);
        chk(conv == 1'b0 && sck == 1'b0, "R10 gated in nap", int'({conv, sck}), 0);
        chk(ready == 1'b0, "R11 ready low in nap", int'(ready), 0);
        ign_req(2'd1, 1'b0, "R9 nap->nap");

        // R6 wake from nap
        do_req(2'd0, 1, HI+LO+NW, 1'b1, "R6 nap wake", 1'b0);
        #1;
        chk(conv == 1'b1 && sck == 1'b1, "R10 pass-through after wake", int'({conv, sck}), 3);

        // R3 sleep from normal
        do_req(2'd2, 4, 4*(HI+LO), 1'b0, "R3 sleep from normal", 1'b0);
        ign_req(2'd1, 1'b0, "R9 sleep->nap");
        ign_req(2'd2, 1'b0, "R9 sleep->sleep");
        chk(conv == 1'b0 && sck == 1'b0, "R10 gated in sleep", int'({conv, sck}), 0);

        // R7 wake from sleep
        do_req(2'd0, 1, HI+LO+SW, 1'b1, "R7 sleep wake", 1'b0);

        // R3 sleep from nap, then R7 wake
        do_req(2'd1, 2, 2*(HI+LO), 1'b0, "R2 nap entry again", 1'b0);
        do_req(2'd2, 4, 4*(HI+LO), 1'b0, "R3 sleep from nap", 1'b0);
        do_req(2'd0, 1, HI+LO+SW, 1'b1, "R7 sleep wake again", 1'b0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all sequences seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 20000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule